// File: doc/BRIEF.md
# Rank Sparing Failover Controller

This block looks after one memory channel that has several active ranks and one extra rank held in reserve. The reserve rank does not count toward usable capacity. Correctable-error reports come in as single-cycle pulses, each tagged with the rank that produced it. The controller counts these reports per rank over a repeating window of programmable length. Every counter returns to zero when a window ends.

A rank whose count reaches the programmable threshold inside one window is taken out of service online. The copy engine visits every word of that rank in ascending address order. For each word it reads the source, writes the value into the reserve rank, reads both copies back and compares them. While the copy runs, a mirror indication tells the host write path to send writes aimed at the failing rank to the reserve rank as well, which keeps the two copies coherent. A compare mismatch repeats the current word. If the mismatch persists past the retry limit, the controller stops with a fatal flag.

When every word matches, the remap output names the retired rank. From then on the host decoder steers that rank's accesses to the reserve, and the retired rank's capacity is given up for good. Only one failover can take place on a channel. Any later threshold hit only raises a sticky alarm.

Top module: `rank_spare_ctrl`

## Requirements
- R1: After reset, remap_valid, busy, mirror_active, alarm, fatal and mem_req_valid are all low.
- R2: Error reports are counted per rank within a window of window_len cycles. All counts clear when the window ends, and a report that arrives in the ending cycle counts toward the new window. Reports that fall in different windows never add up.
- R3: Failover starts for a rank in the cycle its count within the current window becomes equal to threshold. The count saturates at threshold, so further reports on that rank cause no new event. A threshold of 0 disables triggering. Reports carrying a rank ID of ACTIVE_RANKS or above are ignored.
- R4: The copy handles addresses 0 to 2^AW-1 in ascending order. Each address takes exactly four accepted requests in this order: read the source, write the reserve, read the source, read the reserve. The reserve rank has ID ACTIVE_RANKS.
- R5: On a compare mismatch, the same address is repeated with a fresh read and write, up to 3 times. A fourth mismatch sets fatal, stops the copy and leaves remap_valid low.
- R6: Once every address has matched, remap_valid goes high with remap_rank equal to the source rank, and both hold until reset. At that point the reserve contents equal the source contents, and the other ranks are left untouched.
- R7: During the copy, mirror_active is high and mirror_rank gives the source rank.
- R8: Only one failover happens per channel. A threshold hit on any other rank while the reserve is in use or consumed (copying, remapped or fatal) sets a sticky alarm and leaves the remap unchanged. Reports on a retired rank are ignored.
- R9: The memory request port uses valid/ready. A request whose valid is high holds valid, write, rank, address and data stable until ready is seen. Writes only ever target the reserve rank. At most one read is outstanding, and its data is taken on the cycle mem_rsp_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Correctable-error report pulse |
| err_rank | input | RW | Rank that reported the error |
| threshold | input | CNT_W | Reports per window that trigger failover (0 disables) |
| window_len | input | WIN_W | Window length in cycles |
| mem_req_valid | output | 1 | Copy request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_rank | output | RW | Target rank of the request |
| mem_req_addr | output | AW | Word address within the rank |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |
| mirror_active | output | 1 | Host writes to mirror_rank must also go to the reserve |
| mirror_rank | output | RW | Rank being copied |
| remap_valid | output | 1 | Failover complete, remap in force |
| remap_rank | output | RW | Retired rank, now served by the reserve |
| busy | output | 1 | Copy in progress |
| alarm | output | 1 | Sticky: threshold hit with no reserve available |
| fatal | output | 1 | Copy abandoned after the retry limit |

## Verification
The checker watches several rules on every cycle. It confirms that a stalled memory request keeps its fields stable. It confirms that writes only reach the reserve rank and that remap state, once set, never changes. It also confirms that alarm is sticky and that fatal and remap are mutually exclusive. Other behaviour can only be shown by the bench's scenarios:
- the windowed counting and the exact threshold crossing
- the per-address request order
- the retry count before the fatal stop
- the final contents of the reserve rank for every source rank and threshold value

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [3:0] {
    CP_IDLE, CP_RD, CP_RDW, CP_WR, CP_V1, CP_V1W, CP_V2, CP_V2W, CP_DONE, CP_FATAL
  } cp_state_e;
endpackage

// File: rtl/rsp_err_window.sv
module rsp_err_window #(
  parameter int ACTIVE = 3,
  parameter int RW     = 2,
  parameter int CW     = 8,
  parameter int WW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [RW-1:0]     err_rank,
  input  logic [CW-1:0]     threshold,
  input  logic [WW-1:0]     window_len,
  input  logic [ACTIVE-1:0] retired,
  output logic              hit_valid,
  output logic [RW-1:0]     hit_rank
);
  logic [WW-1:0]     win_q;
  logic              expire;
  logic [ACTIVE-1:0] hit_vec;

  // a window closes on its last cycle; the report in that cycle opens the next count
  assign expire = ({1'b0, win_q} + 1'b1) >= {1'b0, window_len};

  always_ff @(posedge clk) begin
    if (!rst_n)      win_q <= '0;
    else if (expire) win_q <= '0;
    else             win_q <= win_q + 1'b1;
  end

  for (genvar i = 0; i < ACTIVE; i++) begin : g_rank
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] base;
    logic          inc;
    assign base = expire ? '0 : cnt_q;
    assign inc  = err_valid && (err_rank == RW'(i)) && !retired[i] &&
                  (threshold != '0) && (base < threshold);
    assign hit_vec[i] = inc && ((base + CW'(1)) == threshold);
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= base + {{(CW-1){1'b0}}, inc};
    end
  end

  always_comb begin
    hit_valid = |hit_vec;
    hit_rank  = '0;
    for (int i = 0; i < ACTIVE; i++)
      if (hit_vec[i]) hit_rank = RW'(i);
  end
endmodule

// File: rtl/rsp_copy_engine.sv
module rsp_copy_engine
  import rsp_pkg::*;
#(
  parameter int            RW        = 2,
  parameter int            AW        = 4,
  parameter int            DW        = 8,
  parameter int            MAX_RETRY = 3,
  parameter logic [RW-1:0] SPARE_ID  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] start_rank,
  output logic          busy,
  output logic          done,
  output logic          fatal,
  output logic [RW-1:0] src_rank,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [RW-1:0] mem_req_rank,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam int RTW = $clog2(MAX_RETRY + 1);

  cp_state_e      state_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  copy_q, v1_q;
  logic [RTW-1:0] retry_q;
  logic [RW-1:0]  src_q;

  assign busy     = !(state_q inside {CP_IDLE, CP_DONE, CP_FATAL});
  assign done     = state_q == CP_DONE;
  assign fatal    = state_q == CP_FATAL;
  assign src_rank = src_q;

  assign mem_req_valid = state_q inside {CP_RD, CP_WR, CP_V1, CP_V2};
  assign mem_req_write = state_q == CP_WR;
  assign mem_req_rank  = (state_q inside {CP_WR, CP_V2}) ? SPARE_ID : src_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = copy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CP_IDLE;
      addr_q  <= '0;
      copy_q  <= '0;
      v1_q    <= '0;
      retry_q <= '0;
      src_q   <= '0;
    end else begin
      case (state_q)
        CP_IDLE: if (start) begin
          src_q   <= start_rank;
          addr_q  <= '0;
          retry_q <= '0;
          state_q <= CP_RD;
        end
        CP_RD:  if (mem_req_ready) state_q <= CP_RDW;
        CP_RDW: if (mem_rsp_valid) begin copy_q <= mem_rsp_data; state_q <= CP_WR; end
        CP_WR:  if (mem_req_ready) state_q <= CP_V1;
        CP_V1:  if (mem_req_ready) state_q <= CP_V1W;
        CP_V1W: if (mem_rsp_valid) begin v1_q <= mem_rsp_data; state_q <= CP_V2; end
        CP_V2:  if (mem_req_ready) state_q <= CP_V2W;
        CP_V2W: if (mem_rsp_valid) begin
          if (mem_rsp_data == v1_q) begin
            retry_q <= '0;
            if (addr_q == {AW{1'b1}}) state_q <= CP_DONE;
            else begin addr_q <= addr_q + 1'b1; state_q <= CP_RD; end
          end else if (retry_q == RTW'(MAX_RETRY)) begin
            state_q <= CP_FATAL;
          end else begin
            retry_q <= retry_q + 1'b1;
            state_q <= CP_RD;
          end
        end
        default: state_q <= state_q;
      endcase
    end
  end
endmodule

// File: rtl/rank_spare_ctrl.sv
module rank_spare_ctrl #(
  parameter int ACTIVE_RANKS = 3,
  parameter int AW           = 4,
  parameter int DW           = 8,
  parameter int CNT_W        = 8,
  parameter int WIN_W        = 16,
  parameter int MAX_RETRY    = 3,
  localparam int RW          = $clog2(ACTIVE_RANKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic [RW-1:0]    err_rank,
  input  logic [CNT_W-1:0] threshold,
  input  logic [WIN_W-1:0] window_len,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [RW-1:0]    mem_req_rank,
  output logic [AW-1:0]    mem_req_addr,
  output logic [DW-1:0]    mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             mirror_active,
  output logic [RW-1:0]    mirror_rank,
  output logic             remap_valid,
  output logic [RW-1:0]    remap_rank,
  output logic             busy,
  output logic             alarm,
  output logic             fatal
);
  localparam logic [RW-1:0] SPARE_ID = RW'(ACTIVE_RANKS);

  logic                    hit_valid;
  logic [RW-1:0]           hit_rank;
  logic [ACTIVE_RANKS-1:0] retired;
  logic                    eng_busy, eng_done, eng_fatal, eng_idle;
  logic [RW-1:0]           src_rank;
  logic                    alarm_q;

  for (genvar i = 0; i < ACTIVE_RANKS; i++) begin : g_ret
    assign retired[i] = eng_done && (src_rank == RW'(i));
  end

  rsp_err_window #(
    .ACTIVE(ACTIVE_RANKS), .RW(RW), .CW(CNT_W), .WW(WIN_W)
  ) u_win (
    .clk, .rst_n, .err_valid, .err_rank, .threshold, .window_len,
    .retired, .hit_valid, .hit_rank
  );

  assign eng_idle = !eng_busy && !eng_done && !eng_fatal;

  rsp_copy_engine #(
    .RW(RW), .AW(AW), .DW(DW), .MAX_RETRY(MAX_RETRY), .SPARE_ID(SPARE_ID)
  ) u_copy (
    .clk, .rst_n,
    .start(hit_valid && eng_idle), .start_rank(hit_rank),
    .busy(eng_busy), .done(eng_done), .fatal(eng_fatal), .src_rank,
    .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_rank,
    .mem_req_addr, .mem_req_wdata, .mem_rsp_valid, .mem_rsp_data
  );

  // the reserve is single-use: any hit after it is claimed can only be flagged
  always_ff @(posedge clk) begin
    if (!rst_n)                       alarm_q <= 1'b0;
    else if (hit_valid && !eng_idle)  alarm_q <= 1'b1;
  end

  assign mirror_active = eng_busy;
  assign mirror_rank   = src_rank;
  assign remap_valid   = eng_done;
  assign remap_rank    = src_rank;
  assign busy          = eng_busy;
  assign alarm         = alarm_q;
  assign fatal         = eng_fatal;
endmodule

// File: rtl/rank_spare_ctrl_sva.sv
module rank_spare_ctrl_sva #(
  parameter int RW    = 2,
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int SPARE = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [RW-1:0] mem_req_rank,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          mirror_active,
  input logic          remap_valid,
  input logic [RW-1:0] remap_rank,
  input logic          alarm,
  input logic          fatal
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_write) &&
    $stable(mem_req_rank) && $stable(mem_req_addr) && $stable(mem_req_wdata));

  p_write_spare_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_rank == RW'(SPARE));

  p_remap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    remap_valid |=> remap_valid && $stable(remap_rank));

  p_fatal_no_remap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> !remap_valid);

  p_alarm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> alarm);

  p_mirror_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_active |-> !remap_valid && !fatal);
endmodule

bind rank_spare_ctrl rank_spare_ctrl_sva #(
  .RW(RW), .AW(AW), .DW(DW), .SPARE(ACTIVE_RANKS)
) u_sva (.*);

// File: tb/rank_spare_ctrl_tb_top.sv
module rank_spare_ctrl_tb_top;
  localparam int NR = 3, AW = 4, DW = 8, RW = 2, WORDS = 1 << AW, SP = NR;

  logic clk = 1'b0, rst_n = 1'b0;
  logic err_valid = 1'b0;
  logic [RW-1:0] err_rank = '0;
  logic [7:0] threshold = 8'd1;
  logic [15:0] window_len = 16'd1000;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [RW-1:0] mem_req_rank;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic mirror_active, remap_valid, busy, alarm, fatal;
  logic [RW-1:0] mirror_rank, remap_rank;

  always #10 clk = ~clk;

  rank_spare_ctrl dut_i (.*);

  int n_checks = 0, n_err = 0;
  logic [DW-1:0] mem [0:3][0:WORDS-1];
  int stuck_addr = -1, flip_addr = -1;
  bit flip_used = 0, check_order = 0;
  int spare_writes = 0, req_count = 0, order_errs = 0, src_r = 0;
  logic [1:0] rdy_ph = '0;

  assign mem_req_ready = rdy_ph != 2'd2;

  function automatic logic [DW-1:0] pat(int r, int a);
    return DW'((r * 37 + a * 11 + 5) % 256);
  endfunction

  always @(posedge clk) begin
    rdy_ph <= rdy_ph + 1'b1;
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (check_order) begin
        automatic int st = req_count % 4;
        automatic int ea = req_count / 4;
        automatic int er = (st == 1 || st == 3) ? SP : src_r;
        if (int'(mem_req_addr) != ea || int'(mem_req_rank) != er ||
            mem_req_write != (st == 1)) order_errs++;
      end
      req_count++;
      if (mem_req_write) begin
        mem[mem_req_rank][mem_req_addr] <= mem_req_wdata;
        if (int'(mem_req_rank) == SP) spare_writes++;
      end else begin
        automatic logic [DW-1:0] d = mem[mem_req_rank][mem_req_addr];
        if (int'(mem_req_rank) == SP && int'(mem_req_addr) == stuck_addr) d ^= 8'h01;
        if (int'(mem_req_rank) == SP && int'(mem_req_addr) == flip_addr && !flip_used) begin
          d ^= 8'h10; flip_used = 1;
        end
        mem_rsp_data  <= d;
        mem_rsp_valid <= 1'b1;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; err_valid = 1'b0;
    for (int r = 0; r < 4; r++)
      for (int a = 0; a < WORDS; a++) mem[r][a] = (r == SP) ? 8'h00 : pat(r, a);
    stuck_addr = -1; flip_addr = -1; flip_used = 0; check_order = 0;
    spare_writes = 0; req_count = 0; order_errs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(int r);
    err_valid = 1'b1; err_rank = RW'(r);
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic spare_vs(string req, int r);
    int bad = 0;
    for (int a = 0; a < WORDS; a++) if (mem[SP][a] != pat(r, a)) bad++;
    chk(req, bad, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 remap_valid", remap_valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 mirror_active", mirror_active, 0);
    chk("R1 alarm", alarm, 0);
    chk("R1 fatal", fatal, 0);
    chk("R1 mem_req_valid", mem_req_valid, 0);

    // sweep: every source rank x thresholds 1..3
    for (int t = 1; t <= 3; t++) begin
      for (int r = 0; r < NR; r++) begin
        do_reset();
        threshold = 8'(t); window_len = 16'd1000; src_r = r; check_order = 1;
        for (int k = 0; k < t - 1; k++) pulse(r);
        chk("R3 no start below threshold", busy, 0);
        pulse(r);
        chk("R3 start at threshold", busy, 1);
        chk("R7 mirror_active", mirror_active, 1);
        chk("R7 mirror_rank", mirror_rank, r);
        pulse(r);  // saturated source count: no new event
        wait_idle();
        chk("R3 saturation no alarm", alarm, 0);
        chk("R6 remap_valid", remap_valid, 1);
        chk("R6 remap_rank", remap_rank, r);
        spare_vs("R6 spare contents", r);
        for (int o = 0; o < NR; o++)
          if (o != r) for (int a = 0; a < WORDS; a++)
            chk("R6 other rank untouched", mem[o][a], pat(o, a));
        chk("R4 spare write count", spare_writes, WORDS);
        chk("R4 request order", order_errs, 0);
      end
    end

    // threshold 0 disables; out-of-range rank ignored
    do_reset();
    threshold = 8'd0;
    repeat (5) pulse(1);
    chk("R3 threshold zero", busy, 0);
    threshold = 8'd1;
    pulse(3);
    chk("R3 invalid rank ignored", busy + remap_valid, 0);

    // window expiry clears counts
    do_reset();
    threshold = 8'd2; window_len = 16'd10;
    pulse(1);
    repeat (12) @(negedge clk);
    pulse(1);
    chk("R2 counts cleared across windows", busy, 0);
    window_len = 16'd1000;
    pulse(2); pulse(2);
    chk("R2 counts add within window", busy, 1);
    wait_idle();
    chk("R2 remap_rank", remap_rank, 2);

    // retired rank ignored; later hit only alarms
    do_reset();
    threshold = 8'd1; window_len = 16'd1000;
    pulse(0);
    wait_idle();
    pulse(0);
    chk("R8 retired rank ignored", alarm, 0);
    pulse(1);
    chk("R8 second hit alarms", alarm, 1);
    chk("R8 remap unchanged", remap_rank, 0);
    chk("R8 no second copy", busy, 0);

    // hit on another rank during copy
    do_reset();
    pulse(1);
    pulse(2);
    chk("R8 alarm during copy", alarm, 1);
    wait_idle();
    chk("R8 remap keeps first", remap_rank, 1);
    spare_vs("R8 spare from first rank", 1);

    // transient mismatch: one retry
    do_reset();
    flip_addr = 5;
    pulse(0);
    wait_idle();
    chk("R5 retry completes", remap_valid, 1);
    chk("R5 retry write count", spare_writes, WORDS + 1);
    chk("R5 no fatal", fatal, 0);
    spare_vs("R5 spare after retry", 0);

    // persistent mismatch: fatal after 3 retries
    do_reset();
    stuck_addr = 7;
    pulse(2);
    wait_idle();
    chk("R5 fatal", fatal, 1);
    chk("R5 fatal no remap", remap_valid, 0);
    chk("R5 fatal write count", spare_writes, 7 + 4);
    chk("R5 fatal stops requests", mem_req_valid, 0);
    pulse(0);
    chk("R8 hit after fatal alarms", alarm, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule